// File: doc/BRIEF.md
# Serial Potentiometer Command Front End

This block is the serial slave logic of a chip that holds two digitally set potentiometers, each with one wiper register and four data registers. A host drives chip select, a serial clock and a serial data line. The block samples those pins in its own system clock domain and checks an addressed identification byte. It then decodes an instruction byte and turns the rest of the transaction into single-cycle strobes that go to a separate wiper and register bank. The strobes cover wiper writes, data register writes, transfers between registers and single-tap steps. Read data from the bank is shifted back out on a serial output.

Writes to the data registers count as nonvolatile. They are held back until chip select rises. At that point the block issues the register strobe and starts a commit timer that runs for a set number of system clocks. While the timer runs, a write-in-progress flag is set, and the host can read it with a status command. A pause input freezes the shift sequence without losing it. A write-protect input prevents the commit. Until the first falling edge of chip select after reset, the block ignores all bus activity.

Top module: `pot_spi_decoder`

## Requirements
- R1: The first byte after chip select falls is the identification byte, sent MSB first. Its bits [7:4] must be 0101, its bits [3:2] must be 00 and its bits [1:0] must equal `addr_strap`. On any mismatch the block ignores the rest of the transaction: no strobe, and no change to any register.
- R2: The second byte is the instruction byte. Bits [7:4] hold the opcode, bits [3:2] select one of four data registers (`sel_reg`) and bit 0 selects the pot (`sel_pot`). The opcodes are: 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 0101 read status, 1101 data register to wiper, 1110 wiper to data register, 0001 data register to wiper for both pots, 1000 wiper to data register for both pots, and 0010 step. At most one strobe is active in any cycle.
- R3: SI is taken on the rising edge of SCK. SO changes after the falling edge of SCK, MSB first. `so_en` is low whenever chip select is high, and it is high during an accepted transaction.
- R4: After reset, no transaction is accepted until chip select has gone from high to low.
- R5: While HOLD is low, SCK edges are ignored. HOLD may only change while SCK is low. The sequence then resumes where it stopped.
- R6: Write wiper pulses `wcr_wr` with `wdata` equal to bits [5:0] of the third byte. The two data-register-to-wiper opcodes pulse `xfer_to_wcr` as soon as the instruction byte is complete. For the both-pots form, `sel_all` is 1.
- R7: Read wiper and read data register return the byte {00, value} in the third byte time.
- R8: Read status returns {0000000, wip} in the third byte time.
- R9: In step mode, each SCK rising edge after the instruction byte pulses `step`. `step_up` equals SI at that edge. This continues until chip select rises.
- R10: A completed write of a data register, or a wiper-to-data-register transfer, is applied when chip select rises. The `dr_wr` or `xfer_to_dr` strobe fires in the cycle after that rising edge is detected. `wip` is then high for exactly COMMIT_CYC system clocks.
- R11: The pending nonvolatile write is dropped if `wp_n` is low when chip select rises, or if `wip` is already set at that moment.
- R12: Opcodes that are not listed in R2 cause the rest of the transaction to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause, active low |
| wp_n | input | 1 | Write protect, active low |
| addr_strap | input | 2 | Device address straps |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for SO (pin is high impedance when 0) |
| wip | output | 1 | Nonvolatile commit in progress |
| sel_pot | output | 1 | Selected pot |
| sel_reg | output | 2 | Selected data register |
| sel_all | output | 1 | Transfer applies to both pots |
| rd_src_dr | output | 1 | Bank read source: 1 data register, 0 wiper |
| rd_data | input | WIPER_W | Value read from the bank at the current selection |
| wdata | output | WIPER_W | Write value |
| wcr_wr | output | 1 | Wiper write strobe |
| dr_wr | output | 1 | Data register write strobe |
| xfer_to_wcr | output | 1 | Data register to wiper transfer strobe |
| xfer_to_dr | output | 1 | Wiper to data register transfer strobe |
| step | output | 1 | Wiper step strobe |
| step_up | output | 1 | Step direction, 1 toward the high terminal |

## Verification
A wrong byte phase or bit count corrupts the next transaction. It shows up as a wrong value when a register is read back, or as a strobe aimed at the wrong register. A wrong pending-commit flag or a wrong commit counter shows up at the `wip` port. That port is checked at the start of the commit, and the number of cycles it stays high is counted. A bad hold or arming state lets stray SCK edges through. That shows up as a changed wiper or an unexpected strobe within the same transaction.

// File: rtl/pot_spi_pkg.sv
package pot_spi_pkg;

  typedef enum logic [3:0] {
    OP_GDR2WCR = 4'b0001,
    OP_STEP    = 4'b0010,
    OP_RDST    = 4'b0101,
    OP_GWCR2DR = 4'b1000,
    OP_RDWCR   = 4'b1001,
    OP_WRWCR   = 4'b1010,
    OP_RDDR    = 4'b1011,
    OP_WRDR    = 4'b1100,
    OP_DR2WCR  = 4'b1101,
    OP_WCR2DR  = 4'b1110
  } pot_op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ID, PH_INSTR, PH_DATA, PH_STEP, PH_DONE
  } pot_phase_e;

  localparam logic [3:0] DEV_TYPE = 4'b0101;

  // identification byte acceptance
  function automatic logic id_ok(input logic [7:0] b, input logic [1:0] strap);
    return (b[7:4] == DEV_TYPE) && (b[3:2] == 2'b00) && (b[1:0] == strap);
  endfunction

  function automatic logic [7:0] status_frame(input logic busy);
    return {7'b0, busy};
  endfunction

  function automatic logic is_read(input pot_op_e op);
    return (op == OP_RDWCR) || (op == OP_RDDR) || (op == OP_RDST);
  endfunction

endpackage

// File: rtl/pot_spi_sync.sv
module pot_spi_sync #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[i]  = s2;
    assign rise[i] = s2 & ~s3;
    assign fall[i] = ~s2 & s3;
  end
endmodule

// File: rtl/pot_nv_commit.sv
module pot_nv_commit #(
  parameter int COMMIT_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic wip
);
  localparam int CW = $clog2(COMMIT_CYC + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           remain <= '0;
    else if (go)          remain <= CW'(COMMIT_CYC);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign wip = (remain != '0);
endmodule

// File: rtl/pot_cmd_engine.sv
module pot_cmd_engine
  import pot_spi_pkg::*;
#(
  parameter int WIPER_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_lvl,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sck_lvl,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               si_lvl,
  input  logic               hold_lvl,
  input  logic               wp_lvl,
  input  logic [1:0]         strap,
  input  logic [WIPER_W-1:0] rd_data,
  input  logic               wip,
  output logic               commit_go,
  output logic               active,
  output logic               hold_act,
  output logic               bit_evt,
  output logic               so,
  output logic               so_en,
  output logic               sel_pot,
  output logic [1:0]         sel_reg,
  output logic               sel_all,
  output logic               rd_src_dr,
  output logic [WIPER_W-1:0] wdata,
  output logic               wcr_wr,
  output logic               dr_wr,
  output logic               xfer_to_wcr,
  output logic               xfer_to_dr,
  output logic               step,
  output logic               step_up
);
  localparam int PAD = 8 - WIPER_W;  // wiper width must be below 8

  logic       armed, pending, pend_xfer, load_so, fall_evt, byte_done;
  logic [6:0] sh;
  logic [7:0] byte_in, so_sr;
  logic [2:0] bit_cnt;
  pot_phase_e phase;
  pot_op_e    op, op_in;

  assign active    = armed & ~cs_lvl;
  assign bit_evt   = sck_rise & active & ~hold_act;
  assign fall_evt  = sck_fall & active & ~hold_act;
  assign byte_in   = {sh, si_lvl};
  assign byte_done = bit_evt && (bit_cnt == 3'd7);
  assign op_in     = pot_op_e'(byte_in[7:4]);
  assign commit_go = cs_rise & pending & wp_lvl & ~wip;
  assign so_en     = active & ~hold_act;

  // pause tracking: only changes while the serial clock is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_act <= 1'b0;
    else if (cs_lvl)   hold_act <= 1'b0;
    else if (!sck_lvl) hold_act <= ~hold_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; phase <= PH_IDLE; bit_cnt <= '0; sh <= '0;
      op <= OP_RDST; sel_pot <= 1'b0; sel_reg <= '0; sel_all <= 1'b0;
      rd_src_dr <= 1'b0; wdata <= '0; pending <= 1'b0; pend_xfer <= 1'b0;
      load_so <= 1'b0; so_sr <= '0; so <= 1'b0;
      wcr_wr <= 1'b0; dr_wr <= 1'b0; xfer_to_wcr <= 1'b0; xfer_to_dr <= 1'b0;
      step <= 1'b0; step_up <= 1'b0;
    end else begin
      wcr_wr <= 1'b0; dr_wr <= 1'b0; xfer_to_wcr <= 1'b0; xfer_to_dr <= 1'b0;
      step <= 1'b0;
      if (load_so) begin
        so_sr   <= (op == OP_RDST) ? status_frame(wip) : {{PAD{1'b0}}, rd_data};
        load_so <= 1'b0;
      end
      if (cs_fall) begin
        armed   <= 1'b1;
        phase   <= PH_ID;
        bit_cnt <= '0;
        so      <= 1'b0;
      end else if (cs_rise) begin
        phase   <= PH_IDLE;
        pending <= 1'b0;
        if (commit_go) begin
          dr_wr      <= ~pend_xfer;
          xfer_to_dr <= pend_xfer;
        end
      end else if (bit_evt) begin
        sh      <= byte_in[6:0];
        bit_cnt <= bit_cnt + 1'b1;
        unique case (phase)
          PH_ID: if (byte_done) phase <= id_ok(byte_in, strap) ? PH_INSTR : PH_DONE;
          PH_INSTR: if (byte_done) begin
            op      <= op_in;
            sel_reg <= byte_in[3:2];
            sel_pot <= byte_in[0];
            sel_all <= 1'b0;
            phase   <= PH_DONE;
            case (op_in)
              OP_RDWCR: begin rd_src_dr <= 1'b0; load_so <= 1'b1; phase <= PH_DATA; end
              OP_RDDR:  begin rd_src_dr <= 1'b1; load_so <= 1'b1; phase <= PH_DATA; end
              OP_RDST:  begin load_so <= 1'b1; phase <= PH_DATA; end
              OP_WRWCR, OP_WRDR: phase <= PH_DATA;
              OP_DR2WCR:  xfer_to_wcr <= 1'b1;
              OP_GDR2WCR: begin xfer_to_wcr <= 1'b1; sel_all <= 1'b1; end
              OP_WCR2DR:  begin pending <= 1'b1; pend_xfer <= 1'b1; end
              OP_GWCR2DR: begin pending <= 1'b1; pend_xfer <= 1'b1; sel_all <= 1'b1; end
              OP_STEP:    phase <= PH_STEP;
              default:    phase <= PH_DONE;
            endcase
          end
          PH_DATA: if (byte_done) begin
            phase <= PH_DONE;
            if (op == OP_WRWCR) begin
              wcr_wr <= 1'b1;
              wdata  <= byte_in[WIPER_W-1:0];
            end else if (op == OP_WRDR) begin
              pending   <= 1'b1;
              pend_xfer <= 1'b0;
              wdata     <= byte_in[WIPER_W-1:0];
            end
          end
          PH_STEP: begin
            step    <= 1'b1;
            step_up <= si_lvl;
          end
          default: ;
        endcase
      end else if (fall_evt && phase == PH_DATA && is_read(op)) begin
        so    <= so_sr[7];
        so_sr <= {so_sr[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/pot_spi_decoder.sv
module pot_spi_decoder #(
  parameter int WIPER_W    = 6,
  parameter int COMMIT_CYC = 4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               si,
  input  logic               hold_n,
  input  logic               wp_n,
  input  logic [1:0]         addr_strap,
  output logic               so,
  output logic               so_en,
  output logic               wip,
  output logic               sel_pot,
  output logic [1:0]         sel_reg,
  output logic               sel_all,
  output logic               rd_src_dr,
  input  logic [WIPER_W-1:0] rd_data,
  output logic [WIPER_W-1:0] wdata,
  output logic               wcr_wr,
  output logic               dr_wr,
  output logic               xfer_to_wcr,
  output logic               xfer_to_dr,
  output logic               step,
  output logic               step_up
);
  // pin order: cs_n, sck, si, hold_n, wp_n. cs starts low so a held-low
  // select never counts as a falling edge after reset.
  localparam int NPIN = 5;
  logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
  logic commit_go, active, hold_act, bit_evt;

  pot_spi_sync #(.W(NPIN), .RST_VAL(5'b00011)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({cs_n, sck, si, hold_n, wp_n}),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  pot_cmd_engine #(.WIPER_W(WIPER_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(pin_lvl[4]), .cs_fall(pin_fall[4]), .cs_rise(pin_rise[4]),
    .sck_lvl(pin_lvl[3]), .sck_rise(pin_rise[3]), .sck_fall(pin_fall[3]),
    .si_lvl(pin_lvl[2]), .hold_lvl(pin_lvl[1]), .wp_lvl(pin_lvl[0]),
    .strap(addr_strap), .rd_data(rd_data), .wip(wip),
    .commit_go(commit_go), .active(active), .hold_act(hold_act), .bit_evt(bit_evt),
    .so(so), .so_en(so_en), .sel_pot(sel_pot), .sel_reg(sel_reg), .sel_all(sel_all),
    .rd_src_dr(rd_src_dr), .wdata(wdata), .wcr_wr(wcr_wr), .dr_wr(dr_wr),
    .xfer_to_wcr(xfer_to_wcr), .xfer_to_dr(xfer_to_dr), .step(step), .step_up(step_up)
  );

  pot_nv_commit #(.COMMIT_CYC(COMMIT_CYC)) u_commit (
    .clk(clk), .rst_n(rst_n), .go(commit_go), .wip(wip)
  );

  logic unused_pins;
  assign unused_pins = ^{pin_rise[2:0], pin_fall[2:0]};
endmodule

// File: rtl/pot_spi_checker.sv
module pot_spi_checker (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic hold_act,
  input logic bit_evt,
  input logic commit_go,
  input logic so_en,
  input logic wip,
  input logic wcr_wr,
  input logic dr_wr,
  input logic xfer_to_wcr,
  input logic xfer_to_dr,
  input logic step
);
  AST_SO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !active |-> !so_en); // R3
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) hold_act |-> !bit_evt); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wcr_wr, dr_wr, xfer_to_wcr, xfer_to_dr, step})); // R2
  AST_WCR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wcr_wr |=> !wcr_wr); // R6
  AST_STEP_LIVE: assert property (@(posedge clk) disable iff (!rst_n) step |-> $past(active)); // R9
  AST_COMMIT_WIP: assert property (@(posedge clk) disable iff (!rst_n) commit_go |=> wip); // R10
  AST_NV_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_wr || xfer_to_dr) |-> $past(commit_go)); // R10
  AST_NO_NV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> !(dr_wr || xfer_to_dr)); // R11
endmodule

bind pot_spi_decoder pot_spi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .hold_act(hold_act), .bit_evt(bit_evt),
  .commit_go(commit_go), .so_en(so_en), .wip(wip), .wcr_wr(wcr_wr), .dr_wr(dr_wr),
  .xfer_to_wcr(xfer_to_wcr), .xfer_to_dr(xfer_to_dr), .step(step)
);

// File: tb/pot_spi_decoder_bench.sv
module pot_spi_decoder_bench;
  localparam int CLK_PER = 10;
  localparam int HALF    = 6 * CLK_PER;
  localparam int COMMIT  = 1000;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] ID = {4'b0101, 2'b00, STRAP};

  logic clk = 0, rst_n = 0, cs_n = 0, sck = 0, si = 0, hold_n = 1, wp_n = 1;
  logic so, so_en, wip, sel_pot, sel_all, rd_src_dr, wcr_wr, dr_wr;
  logic xfer_to_wcr, xfer_to_dr, step, step_up;
  logic [1:0] sel_reg;
  logic [5:0] rd_data, wdata;
  int checks = 0, fails = 0, wcr_wr_cnt = 0, wip_cycles = 0;

  always #(CLK_PER/2) clk = ~clk;

  pot_spi_decoder #(.WIPER_W(6), .COMMIT_CYC(COMMIT)) u_pot_spi_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .addr_strap(STRAP), .so(so), .so_en(so_en), .wip(wip),
    .sel_pot(sel_pot), .sel_reg(sel_reg), .sel_all(sel_all), .rd_src_dr(rd_src_dr),
    .rd_data(rd_data), .wdata(wdata), .wcr_wr(wcr_wr), .dr_wr(dr_wr),
    .xfer_to_wcr(xfer_to_wcr), .xfer_to_dr(xfer_to_dr), .step(step), .step_up(step_up)
  );

  // register bank driven only by the strobes
  logic [5:0] bwcr [2];
  logic [5:0] bdr  [2][4];
  assign rd_data = rd_src_dr ? bdr[sel_pot][sel_reg] : bwcr[sel_pot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        bwcr[p] <= '0;
        for (int r = 0; r < 4; r++) bdr[p][r] <= '0;
      end
    end else begin
      if (wcr_wr) begin bwcr[sel_pot] <= wdata; wcr_wr_cnt <= wcr_wr_cnt + 1; end
      if (dr_wr) bdr[sel_pot][sel_reg] <= wdata;
      for (int p = 0; p < 2; p++) begin
        if (xfer_to_wcr && (sel_all || p == int'(sel_pot))) bwcr[p] <= bdr[p][sel_reg];
        if (xfer_to_dr && (sel_all || p == int'(sel_pot))) bdr[p][sel_reg] <= bwcr[p];
      end
      if (step) bwcr[sel_pot] <= sat_step(bwcr[sel_pot], step_up);
      if (wip) wip_cycles <= wip_cycles + 1;
    end
  end

  // expected model
  logic [5:0] ewcr [2];
  logic [5:0] edr  [2][4];

  function automatic logic [5:0] sat_step(input logic [5:0] v, input logic up);
    if (up) return (v == 6'd63) ? v : v + 6'd1;
    return (v == 6'd0) ? v : v - 6'd1;
  endfunction

  function automatic logic [7:0] ins(input logic [3:0] opc, input logic [1:0] r, input logic p);
    return {opc, r, 1'b0, p};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    si = b;
    #(HALF);
    r = so;
    sck = 1;
    #(HALF);
    sck = 0;
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i]);
  endtask

  task automatic cs_low;
    cs_n = 0;
    #(2*HALF);
  endtask

  task automatic cs_high;
    sck = 0;
    #(HALF);
    cs_n = 1;
    #(4*HALF);
  endtask

  task automatic txn3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      output logic [7:0] rx);
    logic [7:0] d;
    cs_low;
    sbyte(b0, d);
    sbyte(b1, d);
    sbyte(b2, rx);
    cs_high;
  endtask

  task automatic txn2(input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] d;
    cs_low;
    sbyte(b0, d);
    sbyte(b1, d);
    cs_high;
  endtask

  task automatic wait_idle;
    while (wip) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic rd_wcr(input logic p, output logic [7:0] v);
    txn3(ID, ins(4'b1001, 2'b00, p), 8'h00, v);
  endtask

  task automatic rd_dr(input logic p, input logic [1:0] r, output logic [7:0] v);
    txn3(ID, ins(4'b1011, r, p), 8'h00, v);
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int p = 0; p < 2; p++) begin
      rd_wcr(p[0], v);
      chk(req, v, {2'b00, ewcr[p]});
    end
  endtask

  task automatic do_steps(input logic p, input int n);
    logic [7:0] d;
    logic r, dir;
    cs_low;
    sbyte(ID, d);
    sbyte(ins(4'b0010, 2'b00, p), d);
    for (int i = 0; i < n; i++) begin
      dir = 1'($urandom_range(0, 1));
      sbit(dir, r);
      ewcr[p] = sat_step(ewcr[p], dir);
    end
    cs_high;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, d;
    logic r;
    int base;
    void'($urandom(32'h1234_5eed));
    for (int p = 0; p < 2; p++) begin
      ewcr[p] = '0;
      for (int k = 0; k < 4; k++) edr[p][k] = '0;
    end
    repeat (5) @(posedge clk);
    rst_n = 1;
    #(HALF);
    // reset state (cs_n held low through reset)
    chk("R3 reset so_en", {7'b0, so_en}, 8'h00);
    chk("R10 reset wip", {7'b0, wip}, 8'h00);

    // R4: traffic before any select fall is ignored
    sbyte(ID, d);
    sbyte(ins(4'b1010, 2'b00, 1'b0), d);
    sbyte(8'h05, d);
    chk("R4 no write before arming", 8'(wcr_wr_cnt), 8'h00);
    cs_high;
    check_all("R4 wiper unchanged");

    // R6/R7 basic write and read
    txn3(ID, ins(4'b1010, 2'b00, 1'b0), 8'h15, v);
    ewcr[0] = 6'h15;
    check_all("R6 write wiper");
    cs_low;
    chk("R3 so_en during transaction", {7'b0, so_en}, 8'h01);
    cs_high;
    chk("R3 so_en after select rises", {7'b0, so_en}, 8'h00);

    // R1: address and type mismatch
    txn3({4'b0101, 2'b00, 2'b01}, ins(4'b1010, 2'b00, 1'b0), 8'h33, v);
    txn3({4'b0111, 2'b00, STRAP}, ins(4'b1010, 2'b00, 1'b1), 8'h33, v);
    txn3({4'b0101, 2'b10, STRAP}, ins(4'b1010, 2'b00, 1'b1), 8'h33, v);
    check_all("R1 mismatched id ignored");

    // R12: undefined opcodes
    base = wcr_wr_cnt;
    txn3(ID, ins(4'b0011, 2'b01, 1'b0), 8'h3F, v);
    txn3(ID, ins(4'b0000, 2'b01, 1'b1), 8'h3F, v);
    txn3(ID, ins(4'b1111, 2'b00, 1'b1), 8'h3F, v);
    chk("R12 no strobe on undefined opcode", 8'(wcr_wr_cnt - base), 8'h00);
    check_all("R12 wipers unchanged");

    // R10/R8: nonvolatile write, status, busy window
    wip_cycles = 0;
    txn3(ID, ins(4'b1100, 2'b10, 1'b1), 8'h2D, v);
    edr[1][2] = 6'h2D;
    chk("R10 wip set after commit start", {7'b0, wip}, 8'h01);
    txn3(ID, ins(4'b0101, 2'b00, 1'b0), 8'h00, v);
    chk("R8 status busy", v, 8'h01);
    // R11: write during busy is dropped
    txn3(ID, ins(4'b1100, 2'b11, 1'b1), 8'h09, v);
    wait_idle;
    chk("R10 busy length", 8'(wip_cycles == COMMIT), 8'h01);
    rd_dr(1'b1, 2'b10, v);
    chk("R10 data register written", v, {2'b00, edr[1][2]});
    rd_dr(1'b1, 2'b11, v);
    chk("R11 busy write dropped", v, {2'b00, edr[1][3]});
    txn3(ID, ins(4'b0101, 2'b00, 1'b0), 8'h00, v);
    chk("R8 status idle", v, 8'h00);

    // R11: write protect
    wp_n = 0;
    txn3(ID, ins(4'b1100, 2'b01, 1'b0), 8'h21, v);
    chk("R11 protect keeps wip low", {7'b0, wip}, 8'h00);
    wp_n = 1;
    rd_dr(1'b0, 2'b01, v);
    chk("R11 protected register unchanged", v, {2'b00, edr[0][1]});

    // R5: hold pause in the middle of the data byte
    cs_low;
    sbyte(ID, d);
    sbyte(ins(4'b1010, 2'b00, 1'b1), d);
    sbit(1'b0, r); sbit(1'b0, r); sbit(1'b1, r);
    hold_n = 0;
    #(HALF);
    for (int i = 0; i < 4; i++) sbit(1'b1, r);
    hold_n = 1;
    #(HALF);
    sbit(1'b0, r); sbit(1'b1, r); sbit(1'b0, r); sbit(1'b1, r); sbit(1'b0, r);
    cs_high;
    ewcr[1] = 6'h2A;
    check_all("R5 hold preserves sequence");

    // R9: steps including saturation at the top
    txn3(ID, ins(4'b1010, 2'b00, 1'b0), 8'h3E, v);
    ewcr[0] = 6'h3E;
    cs_low;
    sbyte(ID, d);
    sbyte(ins(4'b0010, 2'b00, 1'b0), d);
    for (int i = 0; i < 4; i++) sbit(1'b1, r);
    sbit(1'b0, r);
    cs_high;
    ewcr[0] = 6'h3E;
    check_all("R9 step saturates and reverses");

    // R6/R10: transfers, global forms
    txn2(ID, ins(4'b1000, 2'b00, 1'b0));
    edr[0][0] = ewcr[0]; edr[1][0] = ewcr[1];
    wait_idle;
    rd_dr(1'b1, 2'b00, v);
    chk("R10 global wiper to register", v, {2'b00, edr[1][0]});
    txn2(ID, ins(4'b0001, 2'b10, 1'b0));
    ewcr[0] = edr[0][2]; ewcr[1] = edr[1][2];
    check_all("R6 global register to wiper");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int sel;
      logic p;
      logic [1:0] rg;
      logic [5:0] val;
      sel = $urandom_range(0, 5);
      p   = 1'($urandom_range(0, 1));
      rg  = 2'($urandom_range(0, 3));
      val = 6'($urandom_range(0, 63));
      case (sel)
        0: begin
          txn3(ID, ins(4'b1010, 2'b00, p), {2'b00, val}, v);
          ewcr[p] = val;
          check_all("R6 random wiper write");
        end
        1: begin
          txn3(ID, ins(4'b1100, rg, p), {2'b00, val}, v);
          edr[p][rg] = val;
          wait_idle;
          rd_dr(p, rg, v);
          chk("R7 random register write", v, {2'b00, edr[p][rg]});
        end
        2: begin
          do_steps(p, $urandom_range(1, 10));
          check_all("R9 random steps");
        end
        3: begin
          txn2(ID, ins(4'b1101, rg, p));
          ewcr[p] = edr[p][rg];
          check_all("R6 register to wiper");
        end
        4: begin
          txn2(ID, ins(4'b1110, rg, p));
          edr[p][rg] = ewcr[p];
          wait_idle;
          rd_dr(p, rg, v);
          chk("R10 wiper to register", v, {2'b00, edr[p][rg]});
        end
        default: begin
          rd_dr(p, rg, v);
          chk("R7 random register read", v, {2'b00, edr[p][rg]});
        end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule